// File: doc/BRIEF.md
# Vectored Interrupt Controller with Dual Targets

This block gathers eleven level-sensitive interrupt inputs and turns each new assertion into a single outbound memory-write message rather than a wire. The message's address and its small data word both come from one of two target registers, and a per-source steering bit selects which one. Software reaches the controller through a simple register port. The port offers the two target registers, an enable mask, the steering register, a pending register that clears itself when touched, and three read-only views: the raw latched levels and two per-target request vectors.

The outbound message uses a valid/ready handshake. When the receiver stalls, new source assertions are not lost. Each is held in a per-source send bit, and the held bits are then drained lowest index first. Within this register map the external-bus source sits on bit 6 and the serial-port source on bit 10. Bit 9 is not implemented in the request views.

Top module: `vic_dual_target`

## Requirements
- R1: After reset, every register reads zero and `msg_valid` is low.
- R2: The level register (offset 0x028) shows, one clock after a change, the current state of every source: a bit is 1 while its source is high and 0 once it goes low.
- R3: A source that goes high while its level bit is 0 produces exactly one outbound message, whatever the mask holds. A source that stays high produces no further message until it has gone low and risen again.
- R4: A source whose steering bit (offset 0x024, bit n for source n) is 1 uses target register 1 (offset 0x010). Otherwise it uses target register 0 (offset 0x004).
- R5: The message address is the selected target register with bits 4:0 forced to zero. The 5-bit message data is bits 4:0 of that register.
- R6: Request view 0 (offset 0x00C) reads level AND mask AND NOT steering. Request view 1 (offset 0x014) reads level AND mask AND steering. Both are limited to the implemented set 0x5FF, so bit 9 always reads 0.
- R7: A pending bit (offset 0x01C, bit n for source n) sets whenever source n produces a new assertion. A read of offset 0x01C returns the value and then clears it. A write of any value to offset 0x01C clears it.
- R8: While `msg_valid` is high and `msg_ready` is low, the message address and data do not change. Assertions that arrive during the stall are each sent once afterwards, lower source index first.
- R9: Writes to the read-only offsets 0x00C, 0x014 and 0x028 change nothing. Reads of any offset outside the map return zero.
- R10: Both target registers store and return all 32 bits. The mask (offset 0x018) and steering register store and return bits 10:0, and the upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 11 | Interrupt source levels, one per bit |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| msg_valid | output | 1 | Outbound message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message address, 32-byte aligned |
| msg_data | output | 5 | Message data word |

## Verification
The message path is exercised four ways, and each separates a different fault:

- A single source held high for many cycles shows whether a held level wrongly repeats its message.
- The same source lowered and raised again shows whether a fresh assertion is missed.
- Sources steered to each target with distinct register contents separate target selection from address alignment.
- A stalled receiver, with a mixed-target burst arriving behind it, shows both loss and reordering, because the drain order is visible in the sequence of targets.

The request views are read with steering patterns that include bit 9, and the mask is shrunk, which separates the mask term from the steering term.

// File: rtl/vic_pkg.sv
// Package: shared sizes and register offsets of the dual-target interrupt
// controller. Assumes byte offsets on a 12-bit register window.
package vic_pkg;
    localparam int unsigned VIC_NSRC = 11;
    localparam int unsigned VIC_AW   = 12;
    localparam int unsigned VIC_DW   = 32;
    localparam int unsigned VIC_LOWB = 5;

    localparam logic [VIC_NSRC-1:0] VIC_REQ_IMPL = 11'h5FF;

    localparam logic [11:0] OFS_TGT0  = 12'h004;
    localparam logic [11:0] OFS_REQ0  = 12'h00C;
    localparam logic [11:0] OFS_TGT1  = 12'h010;
    localparam logic [11:0] OFS_REQ1  = 12'h014;
    localparam logic [11:0] OFS_MASK  = 12'h018;
    localparam logic [11:0] OFS_PEND  = 12'h01C;
    localparam logic [11:0] OFS_STEER = 12'h024;
    localparam logic [11:0] OFS_LEVEL = 12'h028;
endpackage

// File: rtl/vic_regs.sv
// Module: register file. Holds both target registers, mask, steering and
// pending bits, and decodes reads of the derived read-only views.
// Assumes one-cycle access strobes and AW >= 12, DW >= NSRC.
module vic_regs
    import vic_pkg::*;
#(
    parameter int unsigned NSRC = VIC_NSRC,
    parameter int unsigned AW   = VIC_AW,
    parameter int unsigned DW   = VIC_DW,
    parameter logic [NSRC-1:0] REQ_IMPL = VIC_REQ_IMPL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] level,
    input  logic [NSRC-1:0] new_evt,
    output logic [DW-1:0]   tgt0,
    output logic [DW-1:0]   tgt1,
    output logic [NSRC-1:0] steer
);
    logic [DW-1:0]   tgt0_q, tgt1_q;
    logic [NSRC-1:0] mask_q, steer_q, pend_q;
    logic            wr_en, rd_en, pend_touch;
    logic [NSRC-1:0] req0_v, req1_v;

    assign wr_en      = bus_sel && bus_we;
    assign rd_en      = bus_sel && !bus_we;
    assign pend_touch = bus_sel && (bus_addr == AW'(OFS_PEND));
    assign req0_v     = level & mask_q & ~steer_q & REQ_IMPL;
    assign req1_v     = level & mask_q & steer_q & REQ_IMPL;

    // Purpose: update writable registers and the self-clearing pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt0_q  <= '0;
            tgt1_q  <= '0;
            mask_q  <= '0;
            steer_q <= '0;
            pend_q  <= '0;
        end else begin
            if (wr_en) begin
                case (bus_addr)
                    AW'(OFS_TGT0):  tgt0_q  <= bus_wdata;
                    AW'(OFS_TGT1):  tgt1_q  <= bus_wdata;
                    AW'(OFS_MASK):  mask_q  <= bus_wdata[NSRC-1:0];
                    AW'(OFS_STEER): steer_q <= bus_wdata[NSRC-1:0];
                    default: ;
                endcase
            end
            pend_q <= (pend_touch ? '0 : pend_q) | new_evt;
        end
    end

    // Purpose: select read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                AW'(OFS_TGT0):  bus_rdata = tgt0_q;
                AW'(OFS_TGT1):  bus_rdata = tgt1_q;
                AW'(OFS_REQ0):  bus_rdata = DW'(req0_v);
                AW'(OFS_REQ1):  bus_rdata = DW'(req1_v);
                AW'(OFS_MASK):  bus_rdata = DW'(mask_q);
                AW'(OFS_PEND):  bus_rdata = DW'(pend_q);
                AW'(OFS_STEER): bus_rdata = DW'(steer_q);
                AW'(OFS_LEVEL): bus_rdata = DW'(level);
                default:        bus_rdata = '0;
            endcase
        end
    end

    assign tgt0  = tgt0_q;
    assign tgt1  = tgt1_q;
    assign steer = steer_q;
endmodule

// File: rtl/vic_edge_queue.sv
// Module: latches source levels, detects new assertions and keeps one
// send-request bit per source until the output stage grants it.
// Assumes sources are synchronous to clk.
module vic_edge_queue #(
    parameter int unsigned NSRC = vic_pkg::VIC_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic [NSRC-1:0] grant,
    output logic [NSRC-1:0] level,
    output logic [NSRC-1:0] new_evt,
    output logic [NSRC-1:0] send_req
);
    logic [NSRC-1:0] level_q, send_q;

    assign new_evt = src_lvl & ~level_q;

    // Purpose: track levels and accumulate unsent assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            send_q  <= '0;
        end else begin
            level_q <= src_lvl;
            send_q  <= (send_q & ~grant) | new_evt;
        end
    end

    assign level    = level_q;
    assign send_req = send_q;
endmodule

// File: rtl/vic_msg_out.sv
// Module: picks the lowest waiting source, resolves its target register and
// holds the resulting message until the receiver accepts it.
// Assumes the payload is frozen at load time.
module vic_msg_out #(
    parameter int unsigned NSRC = vic_pkg::VIC_NSRC,
    parameter int unsigned DW   = vic_pkg::VIC_DW,
    parameter int unsigned LOWB = vic_pkg::VIC_LOWB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] send_req,
    input  logic [DW-1:0]   tgt0,
    input  logic [DW-1:0]   tgt1,
    input  logic [NSRC-1:0] steer,
    output logic [NSRC-1:0] grant,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [DW-1:0]   msg_addr,
    output logic [LOWB-1:0] msg_data
);
    logic            valid_q;
    logic [DW-1:0]   addr_q, tgt_sel;
    logic [LOWB-1:0] data_q;
    logic [NSRC-1:0] pick;
    logic            load_ok, use_t1;

    assign load_ok = !valid_q || msg_ready;
    assign pick    = send_req & (~send_req + NSRC'(1));
    assign grant   = load_ok ? pick : '0;
    assign use_t1  = |(pick & steer);
    assign tgt_sel = use_t1 ? tgt1 : tgt0;

    // Purpose: load a new message when the slot is free or being drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (load_ok) begin
            valid_q <= |send_req;
            if (|send_req) begin
                addr_q <= {tgt_sel[DW-1:LOWB], {LOWB{1'b0}}};
                data_q <= tgt_sel[LOWB-1:0];
            end
        end
    end

    assign msg_valid = valid_q;
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;
endmodule

// File: rtl/vic_dual_target.sv
// Module: top of the dual-target vectored interrupt controller. Connects the
// register file, the level/send tracker and the message output stage.
// Assumes synchronous active-low reset and synchronous sources.
module vic_dual_target
    import vic_pkg::*;
#(
    parameter int unsigned NSRC = VIC_NSRC,
    parameter int unsigned AW   = VIC_AW,
    parameter int unsigned DW   = VIC_DW,
    parameter int unsigned LOWB = VIC_LOWB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [DW-1:0]   msg_addr,
    output logic [LOWB-1:0] msg_data
);
    logic [NSRC-1:0] level, new_evt, send_req, grant, steer;
    logic [DW-1:0]   tgt0, tgt1;

    vic_regs #(.NSRC(NSRC), .AW(AW), .DW(DW), .REQ_IMPL(VIC_REQ_IMPL)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .level(level), .new_evt(new_evt),
        .tgt0(tgt0), .tgt1(tgt1), .steer(steer)
    );

    vic_edge_queue #(.NSRC(NSRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .grant(grant),
        .level(level), .new_evt(new_evt), .send_req(send_req)
    );

    vic_msg_out #(.NSRC(NSRC), .DW(DW), .LOWB(LOWB)) u_out (
        .clk(clk), .rst_n(rst_n), .send_req(send_req),
        .tgt0(tgt0), .tgt1(tgt1), .steer(steer), .grant(grant),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );
endmodule

// File: rtl/vic_dual_target_chk.sv
// Module: port-level checker for the dual-target interrupt controller.
// Assumes it is bound to every instance of the top module.
module vic_dual_target_chk
    import vic_pkg::*;
#(
    parameter int unsigned NSRC = VIC_NSRC,
    parameter int unsigned AW   = VIC_AW,
    parameter int unsigned DW   = VIC_DW,
    parameter int unsigned LOWB = VIC_LOWB
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_lvl,
    input logic            bus_sel,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_rdata,
    input logic            msg_valid,
    input logic            msg_ready,
    input logic [DW-1:0]   msg_addr,
    input logic [LOWB-1:0] msg_data
);
    logic rd_req, rd_lvl, rd_unmapped;
    assign rd_req = bus_sel && !bus_we &&
                    (bus_addr == AW'(OFS_REQ0) || bus_addr == AW'(OFS_REQ1));
    assign rd_lvl = bus_sel && !bus_we && bus_addr == AW'(OFS_LEVEL);
    assign rd_unmapped = bus_sel && !bus_we &&
        !(bus_addr == AW'(OFS_TGT0) || bus_addr == AW'(OFS_TGT1) ||
          bus_addr == AW'(OFS_REQ0) || bus_addr == AW'(OFS_REQ1) ||
          bus_addr == AW'(OFS_MASK) || bus_addr == AW'(OFS_PEND) ||
          bus_addr == AW'(OFS_STEER) || bus_addr == AW'(OFS_LEVEL));

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !msg_valid); // R1

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lvl && $past(rst_n) |-> bus_rdata[NSRC-1:0] == $past(src_lvl)); // R2

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_addr[LOWB-1:0] == '0); // R5

    AST_REQ_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (bus_rdata[NSRC-1:0] & ~VIC_REQ_IMPL) == '0); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |-> bus_rdata == '0); // R9
endmodule

bind vic_dual_target vic_dual_target_chk #(
    .NSRC(NSRC), .AW(AW), .DW(DW), .LOWB(LOWB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/test_vic_dual_target.sv
// Bench: directed scenarios for the dual-target interrupt controller.
module test_vic_dual_target;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] src_lvl = '0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid, msg_ready = 1'b1;
    logic [31:0] msg_addr;
    logic [4:0]  msg_data;

    int n_chk = 0, n_fail = 0, msg_cnt = 0;
    logic [31:0] log_addr [16];
    logic [4:0]  log_data [16];

    always #5 clk = ~clk;

    vic_dual_target i_vic_dual_target (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Message monitor: records every accepted message.
    initial forever begin
        @(negedge clk); #2;
        if (rst_n && msg_valid && msg_ready) begin
            log_addr[msg_cnt % 16] = msg_addr;
            log_data[msg_cnt % 16] = msg_data;
            msg_cnt++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        @(negedge clk); src_lvl = '0; msg_ready = 1'b1; idle(20);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [11:0] ofs [8] = '{12'h004, 12'h00C, 12'h010, 12'h014,
                                 12'h018, 12'h01C, 12'h024, 12'h028};
        chk("R1", "msg_valid after reset", {31'b0, msg_valid}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd(ofs[i], d);
            chk("R1", $sformatf("reg 0x%03h after reset", ofs[i]), d, 32'h0);
        end
    endtask

    task automatic t_single();
        logic [31:0] d;
        int c0;
        quiet();
        wr(12'h018, 32'h0); wr(12'h024, 32'h0);
        wr(12'h004, 32'h1234_5667);
        c0 = msg_cnt;
        @(negedge clk); src_lvl[2] = 1'b1;
        idle(6);
        chk("R3", "one message on rise, mask clear", msg_cnt, c0 + 1);
        chk("R5", "address from target 0", log_addr[(msg_cnt-1)%16], 32'h1234_5660);
        chk("R5", "data from target 0", {27'b0, log_data[(msg_cnt-1)%16]}, 32'h7);
        rd(12'h028, d);
        chk("R2", "level while high", d, 32'h004);
        idle(10);
        chk("R3", "no repeat while held", msg_cnt, c0 + 1);
        @(negedge clk); src_lvl[2] = 1'b0;
        idle(2);
        rd(12'h028, d);
        chk("R2", "level after drop", d, 32'h0);
        @(negedge clk); src_lvl[2] = 1'b1;
        idle(6);
        chk("R3", "new message after re-rise", msg_cnt, c0 + 2);
    endtask

    task automatic t_steer();
        int c0;
        quiet();
        wr(12'h004, 32'h0000_0A45);
        wr(12'h010, 32'hABCD_EF1F);
        wr(12'h024, 32'h400);
        c0 = msg_cnt;
        @(negedge clk); src_lvl[10] = 1'b1;
        idle(6);
        chk("R4", "serial source steered to target 1", msg_cnt, c0 + 1);
        chk("R4", "target 1 address", log_addr[(msg_cnt-1)%16], 32'hABCD_EF00);
        chk("R5", "target 1 data", {27'b0, log_data[(msg_cnt-1)%16]}, 32'h1F);
        @(negedge clk); src_lvl[6] = 1'b1;
        idle(6);
        chk("R4", "bus source uses target 0", log_addr[(msg_cnt-1)%16], 32'h0000_0A40);
        chk("R5", "target 0 data", {27'b0, log_data[(msg_cnt-1)%16]}, 32'h05);
    endtask

    task automatic t_request();
        logic [31:0] d;
        quiet();
        wr(12'h018, 32'h7FF);
        wr(12'h024, 32'h2F0);
        @(negedge clk); src_lvl = 11'h7FF;
        idle(20);
        rd(12'h00C, d); chk("R6", "request 0 full mask", d, 32'h50F);
        rd(12'h014, d); chk("R6", "request 1 full mask, bit 9 dropped", d, 32'h0F0);
        wr(12'h018, 32'h00F);
        rd(12'h00C, d); chk("R6", "request 0 narrow mask", d, 32'h00F);
        rd(12'h014, d); chk("R6", "request 1 narrow mask", d, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h028, 32'h0);
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h00C, d); chk("R9", "request 0 after write", d, 32'h00F);
        rd(12'h014, d); chk("R9", "request 1 after write", d, 32'h0);
        rd(12'h028, d); chk("R9", "level after write", d, 32'h7FF);
        rd(12'h008, d); chk("R9", "unmapped 0x008", d, 32'h0);
        rd(12'h000, d); chk("R9", "unmapped 0x000", d, 32'h0);
        rd(12'h030, d); chk("R9", "unmapped 0x030", d, 32'h0);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        quiet();
        rd(12'h01C, d);
        @(negedge clk); src_lvl[3] = 1'b1;
        idle(4);
        rd(12'h01C, d); chk("R7", "pending after source 3", d, 32'h008);
        rd(12'h01C, d); chk("R7", "pending cleared by read", d, 32'h0);
        @(negedge clk); src_lvl[5] = 1'b1;
        idle(4);
        wr(12'h01C, 32'h0000_0020);
        rd(12'h01C, d); chk("R7", "pending cleared by write", d, 32'h0);
        @(negedge clk); src_lvl[8] = 1'b1;
        idle(4);
        rd(12'h01C, d); chk("R7", "pending after source 8", d, 32'h100);
    endtask

    task automatic t_stall();
        logic [31:0] a0;
        int c0;
        quiet();
        wr(12'h004, 32'h0000_0100);
        wr(12'h010, 32'h0000_0203);
        wr(12'h024, 32'h002);
        @(negedge clk); msg_ready = 1'b0;
        c0 = msg_cnt;
        src_lvl[7] = 1'b1;
        idle(4);
        chk("R8", "valid during stall", {31'b0, msg_valid}, 32'h1);
        a0 = msg_addr;
        chk("R8", "first address during stall", a0, 32'h0000_0100);
        @(negedge clk); src_lvl[1] = 1'b1; src_lvl[4] = 1'b1;
        idle(5);
        chk("R8", "address held during stall", msg_addr, a0);
        chk("R8", "nothing accepted during stall", msg_cnt, c0);
        @(negedge clk); msg_ready = 1'b1;
        idle(10);
        chk("R8", "all queued sent once", msg_cnt, c0 + 3);
        chk("R8", "order slot 0", log_addr[c0 % 16], 32'h0000_0100);
        chk("R8", "order slot 1 (source 1)", log_addr[(c0+1) % 16], 32'h0000_0200);
        chk("R8", "order slot 2 (source 4)", log_addr[(c0+2) % 16], 32'h0000_0100);
        chk("R8", "data slot 1", {27'b0, log_data[(c0+1) % 16]}, 32'h3);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(12'h004, 32'hDEAD_BEEF);
        wr(12'h010, 32'h1357_9BDF);
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h024, 32'hFFFF_F800);
        rd(12'h004, d); chk("R10", "target 0 readback", d, 32'hDEAD_BEEF);
        rd(12'h010, d); chk("R10", "target 1 readback", d, 32'h1357_9BDF);
        rd(12'h018, d); chk("R10", "mask readback", d, 32'h7FF);
        rd(12'h024, d); chk("R10", "steering readback", d, 32'h0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL all watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_single();
        t_steer();
        t_request();
        t_readonly();
        t_pending();
        t_stall();
        t_readback();
        report();
    end
endmodule